// File: doc/BRIEF.md
# Configuration-Driven Address Window Decoder

This block sits beside the configuration registers of a bus endpoint function. It watches host memory and I/O accesses and tells the rest of the function whether an access falls inside one of its three resources: a 4 KB memory window, a 64-port I/O window and a 32 KB option ROM window. For a matching access it raises that window's select and gives the address offset within the window. Everything else is left to neighbouring logic, including data transfer, bus protocol and ROM contents.

The decoder holds no copy of the configuration. It decodes each access against the values on its configuration inputs in the same cycle as the request: the command enables, the memory base register, the I/O base register and the ROM register. A configuration write therefore takes effect on the very next access, and no remap sequence is needed. Selects and offsets are registered, so they appear one clock after the request. The ROM window is decoded from the memory address, like the memory window. When both windows match, the ROM wins.

Top module: `cfg_window_decoder`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every select reads 0 and every offset reads 0.
- R2: A memory request with `cmdMemEn` high and `memAddr[31:12]` equal to `memBarBase[31:12]` raises `memSel` one cycle later, with `memOffset` equal to `memAddr[11:0]`, unless R8 applies.
- R3: With `cmdMemEn` low, neither `memSel` nor `romSel` is raised, whatever the address and the ROM enable.
- R4: An I/O request with `cmdIoEn` high and `ioAddr[15:6]` equal to `ioBarBase[15:6]` raises `ioSel` one cycle later, with `ioOffset` equal to `ioAddr[5:0]`. The base register's low six bits (type flag in bit 0, reserved bit 1) do not take part in the match.
- R5: With `cmdIoEn` low, `ioSel` is never raised.
- R6: A memory request with `cmdMemEn` high, ROM enable (`romBar` bit 0) high and `memAddr[31:15]` equal to `romBar[31:15]` raises `romSel` one cycle later, with `romOffset` equal to `memAddr[14:0]`.
- R7: With the ROM enable bit (`romBar` bit 0) low, `romSel` is never raised, even when the memory command enable is set.
- R8: When the ROM window and the memory window both match the same access, only `romSel` is raised. `memSel` and `memOffset` then read 0, and `memSel` and `romSel` are never high together.
- R9: The low bits of `memBarBase` below bit 12 do not affect the memory match.
- R10: A cycle with no request gives, one cycle later, all selects low for that request type and the offsets of the deselected windows equal to 0.
- R11: A change to any configuration input in the same cycle as a request is used to decode that request.
- R12: A memory request and an I/O request in the same cycle are decoded independently, and both selects may rise together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdIoEn | input | 1 | Command I/O space enable |
| cmdMemEn | input | 1 | Command memory space enable |
| memBarBase | input | 32 | Memory base register, base in bits 31:12 |
| ioBarBase | input | 16 | I/O base register low half, base in bits 15:6 |
| romBar | input | 32 | Option ROM register: base in bits 31:15, enable in bit 0 |
| memReq | input | 1 | Memory access valid this cycle |
| memAddr | input | 32 | Memory access address |
| ioReq | input | 1 | I/O access valid this cycle |
| ioAddr | input | 16 | I/O access port address |
| memSel | output | 1 | Registered memory window select |
| memOffset | output | 12 | Registered offset within the memory window |
| romSel | output | 1 | Registered ROM window select |
| romOffset | output | 15 | Registered offset within the ROM window |
| ioSel | output | 1 | Registered I/O window select |
| ioOffset | output | 6 | Registered offset within the I/O window |

## Verification
The ROM window and the memory window can both match one memory address in the same cycle. The bench provokes this by placing the memory base inside the ROM's 32 KB range and toggling the ROM enable. It judges the result by requiring that only the ROM select rises, with the memory offset at zero, and that the memory select rises once the ROM is disabled. A memory hit and an I/O hit are also issued together, and a randomized sweep lands addresses near both bases against a behavioural model that works with integer division and remainder.

// File: rtl/cfg_window_pkg.sv
package cfg_window_pkg;

  // Per-window hit strobes passed from the control to the datapath
  typedef struct packed {
    logic memHit;
    logic romHit;
    logic ioHit;
  } winStrobes_t;

  // Position of the enable flag inside the ROM register
  localparam int ROM_EN_BIT = 0;

endpackage

// File: rtl/window_match.sv
module window_match #(
  parameter int AW        = 32,
  parameter int SIZE_LOG2 = 12
) (
  input  logic          enable,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  output logic          hit
);

  // Bits at and above the window size take part in the compare
  localparam logic [AW-1:0] BASE_MASK = ~((AW'(1) << SIZE_LOG2) - AW'(1));

  always_comb begin
    hit = enable && (((addr ^ base) & BASE_MASK) == '0);
  end

endmodule

// File: rtl/cfg_window_decoder_ctrl.sv
module cfg_window_decoder_ctrl
  import cfg_window_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int IO_ADDR_W    = 16,
  parameter int MEM_WIN_LOG2 = 12,
  parameter int IO_WIN_LOG2  = 6,
  parameter int ROM_WIN_LOG2 = 15
) (
  input  logic                 cmdIoEn,
  input  logic                 cmdMemEn,
  input  logic [ADDR_W-1:0]    memBarBase,
  input  logic [IO_ADDR_W-1:0] ioBarBase,
  input  logic [ADDR_W-1:0]    romBar,
  input  logic                 memReq,
  input  logic [ADDR_W-1:0]    memAddr,
  input  logic                 ioReq,
  input  logic [IO_ADDR_W-1:0] ioAddr,
  output winStrobes_t          strobes
);

  logic memRaw;
  logic romRaw;
  logic ioRaw;
  logic memGate;
  logic romGate;
  logic ioGate;

  always_comb begin
    memGate = memReq && cmdMemEn;
    romGate = memGate && romBar[ROM_EN_BIT];
    ioGate  = ioReq && cmdIoEn;
  end

  window_match #(.AW(ADDR_W), .SIZE_LOG2(MEM_WIN_LOG2)) u_memMatch (
    .enable (memGate),
    .addr   (memAddr),
    .base   (memBarBase),
    .hit    (memRaw)
  );

  window_match #(.AW(ADDR_W), .SIZE_LOG2(ROM_WIN_LOG2)) u_romMatch (
    .enable (romGate),
    .addr   (memAddr),
    .base   (romBar),
    .hit    (romRaw)
  );

  window_match #(.AW(IO_ADDR_W), .SIZE_LOG2(IO_WIN_LOG2)) u_ioMatch (
    .enable (ioGate),
    .addr   (ioAddr),
    .base   (ioBarBase),
    .hit    (ioRaw)
  );

  // ROM decode takes priority over the memory window on overlap
  always_comb begin
    strobes.romHit = romRaw;
    strobes.memHit = memRaw && !romRaw;
    strobes.ioHit  = ioRaw;
  end

endmodule

// File: rtl/cfg_window_decoder_dp.sv
module cfg_window_decoder_dp
  import cfg_window_pkg::*;
#(
  parameter int MEM_WIN_LOG2 = 12,
  parameter int IO_WIN_LOG2  = 6,
  parameter int ROM_WIN_LOG2 = 15
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  winStrobes_t             strobes,
  input  logic [MEM_WIN_LOG2-1:0] memLow,
  input  logic [ROM_WIN_LOG2-1:0] romLow,
  input  logic [IO_WIN_LOG2-1:0]  ioLow,
  output logic                    memSel,
  output logic [MEM_WIN_LOG2-1:0] memOffset,
  output logic                    romSel,
  output logic [ROM_WIN_LOG2-1:0] romOffset,
  output logic                    ioSel,
  output logic [IO_WIN_LOG2-1:0]  ioOffset
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      memSel    <= 1'b0;
      romSel    <= 1'b0;
      ioSel     <= 1'b0;
      memOffset <= '0;
      romOffset <= '0;
      ioOffset  <= '0;
    end else begin
      memSel    <= strobes.memHit;
      romSel    <= strobes.romHit;
      ioSel     <= strobes.ioHit;
      memOffset <= strobes.memHit ? memLow : '0;
      romOffset <= strobes.romHit ? romLow : '0;
      ioOffset  <= strobes.ioHit  ? ioLow  : '0;
    end
  end

endmodule

// File: rtl/cfg_window_decoder.sv
module cfg_window_decoder
  import cfg_window_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int IO_ADDR_W    = 16,
  parameter int MEM_WIN_LOG2 = 12,
  parameter int IO_WIN_LOG2  = 6,
  parameter int ROM_WIN_LOG2 = 15
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmdIoEn,
  input  logic                    cmdMemEn,
  input  logic [ADDR_W-1:0]       memBarBase,
  input  logic [IO_ADDR_W-1:0]    ioBarBase,
  input  logic [ADDR_W-1:0]       romBar,
  input  logic                    memReq,
  input  logic [ADDR_W-1:0]       memAddr,
  input  logic                    ioReq,
  input  logic [IO_ADDR_W-1:0]    ioAddr,
  output logic                    memSel,
  output logic [MEM_WIN_LOG2-1:0] memOffset,
  output logic                    romSel,
  output logic [ROM_WIN_LOG2-1:0] romOffset,
  output logic                    ioSel,
  output logic [IO_WIN_LOG2-1:0]  ioOffset
);

  winStrobes_t strobes;

  cfg_window_decoder_ctrl #(
    .ADDR_W(ADDR_W), .IO_ADDR_W(IO_ADDR_W), .MEM_WIN_LOG2(MEM_WIN_LOG2),
    .IO_WIN_LOG2(IO_WIN_LOG2), .ROM_WIN_LOG2(ROM_WIN_LOG2)
  ) u_ctrl (
    .cmdIoEn    (cmdIoEn),
    .cmdMemEn   (cmdMemEn),
    .memBarBase (memBarBase),
    .ioBarBase  (ioBarBase),
    .romBar     (romBar),
    .memReq     (memReq),
    .memAddr    (memAddr),
    .ioReq      (ioReq),
    .ioAddr     (ioAddr),
    .strobes    (strobes)
  );

  cfg_window_decoder_dp #(
    .MEM_WIN_LOG2(MEM_WIN_LOG2), .IO_WIN_LOG2(IO_WIN_LOG2), .ROM_WIN_LOG2(ROM_WIN_LOG2)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .memLow    (memAddr[MEM_WIN_LOG2-1:0]),
    .romLow    (memAddr[ROM_WIN_LOG2-1:0]),
    .ioLow     (ioAddr[IO_WIN_LOG2-1:0]),
    .memSel    (memSel),
    .memOffset (memOffset),
    .romSel    (romSel),
    .romOffset (romOffset),
    .ioSel     (ioSel),
    .ioOffset  (ioOffset)
  );

endmodule

// File: rtl/cfg_window_decoder_chk.sv
module cfg_window_decoder_chk #(
  parameter int MEM_WIN_LOG2 = 12,
  parameter int IO_WIN_LOG2  = 6,
  parameter int ROM_WIN_LOG2 = 15
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cmdIoEn,
  input logic                    cmdMemEn,
  input logic                    romEn,
  input logic                    memReq,
  input logic [ROM_WIN_LOG2-1:0] memAddrLow,
  input logic [IO_WIN_LOG2-1:0]  ioAddrLow,
  input logic                    memSel,
  input logic [MEM_WIN_LOG2-1:0] memOffset,
  input logic                    romSel,
  input logic [ROM_WIN_LOG2-1:0] romOffset,
  input logic                    ioSel,
  input logic [IO_WIN_LOG2-1:0]  ioOffset
);

  // R8: ROM and memory selects are never high together
  a_r8_single_mem_select: assert property (@(posedge clk) disable iff (!rst_n)
    !(memSel && romSel));

  // R3: memory space disabled blocks both memory-side selects
  a_r3_mem_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !cmdMemEn |=> (!memSel && !romSel));

  // R5: I/O space disabled blocks the I/O select
  a_r5_io_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !cmdIoEn |=> !ioSel);

  // R7: ROM enable clear blocks the ROM select
  a_r7_rom_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !romEn |=> !romSel);

  // R10: an idle memory cycle leaves memory-side outputs at zero
  a_r10_idle_mem: assert property (@(posedge clk) disable iff (!rst_n)
    !memReq |=> (!memSel && !romSel && memOffset == '0 && romOffset == '0));

  // R2: memory offset follows the low address bits of the request
  a_r2_mem_offset: assert property (@(posedge clk) disable iff (!rst_n)
    memSel |-> memOffset == $past(memAddrLow[MEM_WIN_LOG2-1:0]));

  // R6: ROM offset follows the low address bits of the request
  a_r6_rom_offset: assert property (@(posedge clk) disable iff (!rst_n)
    romSel |-> romOffset == $past(memAddrLow));

  // R4: I/O offset follows the low port bits of the request
  a_r4_io_offset: assert property (@(posedge clk) disable iff (!rst_n)
    ioSel |-> ioOffset == $past(ioAddrLow));

endmodule

bind cfg_window_decoder cfg_window_decoder_chk #(
  .MEM_WIN_LOG2(MEM_WIN_LOG2), .IO_WIN_LOG2(IO_WIN_LOG2), .ROM_WIN_LOG2(ROM_WIN_LOG2)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmdIoEn    (cmdIoEn),
  .cmdMemEn   (cmdMemEn),
  .romEn      (romBar[0]),
  .memReq     (memReq),
  .memAddrLow (memAddr[ROM_WIN_LOG2-1:0]),
  .ioAddrLow  (ioAddr[IO_WIN_LOG2-1:0]),
  .memSel     (memSel),
  .memOffset  (memOffset),
  .romSel     (romSel),
  .romOffset  (romOffset),
  .ioSel      (ioSel),
  .ioOffset   (ioOffset)
);

// File: tb/cfg_window_decoder_tb.sv
`timescale 1ns/1ps
module cfg_window_decoder_tb;

  localparam longint MEM_SZ = 4096;
  localparam longint IO_SZ  = 64;
  localparam longint ROM_SZ = 32768;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmdIoEn = 1'b0;
  logic        cmdMemEn = 1'b0;
  logic [31:0] memBarBase = '0;
  logic [15:0] ioBarBase = '0;
  logic [31:0] romBar = '0;
  logic        memReq = 1'b0;
  logic [31:0] memAddr = '0;
  logic        ioReq = 1'b0;
  logic [15:0] ioAddr = '0;
  logic        memSel;
  logic [11:0] memOffset;
  logic        romSel;
  logic [14:0] romOffset;
  logic        ioSel;
  logic [5:0]  ioOffset;

  int testsRun = 0;
  int testsFailed = 0;

  always #4 clk = ~clk;

  cfg_window_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cmdIoEn(cmdIoEn), .cmdMemEn(cmdMemEn),
    .memBarBase(memBarBase), .ioBarBase(ioBarBase), .romBar(romBar),
    .memReq(memReq), .memAddr(memAddr), .ioReq(ioReq), .ioAddr(ioAddr),
    .memSel(memSel), .memOffset(memOffset), .romSel(romSel),
    .romOffset(romOffset), .ioSel(ioSel), .ioOffset(ioOffset)
  );

  // Behavioural expectation built from integer division and remainder
  longint expMemSel, expRomSel, expIoSel, expMemOff, expRomOff, expIoOff;

  task automatic predict();
    longint a  = longint'(memAddr);
    longint ia = longint'(ioAddr);
    expRomSel = (memReq && cmdMemEn && romBar[0] &&
                 (a / ROM_SZ) == (longint'(romBar) / ROM_SZ)) ? 1 : 0;
    expMemSel = (memReq && cmdMemEn && expRomSel == 0 &&
                 (a / MEM_SZ) == (longint'(memBarBase) / MEM_SZ)) ? 1 : 0;
    expIoSel  = (ioReq && cmdIoEn &&
                 (ia / IO_SZ) == (longint'(ioBarBase) / IO_SZ)) ? 1 : 0;
    expMemOff = expMemSel != 0 ? a % MEM_SZ : 0;
    expRomOff = expRomSel != 0 ? a % ROM_SZ : 0;
    expIoOff  = expIoSel  != 0 ? ia % IO_SZ : 0;
  endtask

  task automatic check(string tag, string what, longint act, longint exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    check(tag, "memSel",    longint'(memSel),    expMemSel);
    check(tag, "memOffset", longint'(memOffset), expMemOff);
    check(tag, "romSel",    longint'(romSel),    expRomSel);
    check(tag, "romOffset", longint'(romOffset), expRomOff);
    check(tag, "ioSel",     longint'(ioSel),     expIoSel);
    check(tag, "ioOffset",  longint'(ioOffset),  expIoOff);
  endtask

  // Inputs are set at a falling edge; the result is sampled one falling edge later
  task automatic step(string tag);
    predict();
    @(posedge clk);
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    // R1: hitting stimulus held during reset must not reach the outputs
    cmdIoEn = 1; cmdMemEn = 1;
    memBarBase = 32'h8000_1000; ioBarBase = 16'hE041; romBar = 32'h000C_0001;
    memReq = 1; memAddr = 32'h8000_1ABC; ioReq = 1; ioAddr = 16'hE07F;
    repeat (3) @(posedge clk);
    @(negedge clk);
    expMemSel = 0; expRomSel = 0; expIoSel = 0;
    expMemOff = 0; expRomOff = 0; expIoOff = 0;
    compareAll("R1");
    memReq = 0; ioReq = 0;
    rst_n = 1;
    @(posedge clk);
    @(negedge clk);
    compareAll("R1");

    // R3: memory space off blocks memory and ROM hits
    cmdMemEn = 0; memReq = 1; memAddr = 32'h8000_1ABC;
    step("R3");
    memAddr = 32'h000C_0100;
    step("R3");

    // R2: memory window hit and miss
    cmdMemEn = 1; memAddr = 32'h8000_1ABC;
    step("R2");
    memAddr = 32'h8000_2000;
    step("R2");
    memAddr = 32'h8000_0FFF;
    step("R2");

    // R9: junk in the low base bits does not disturb the match
    memBarBase = 32'h8000_1FF7; memAddr = 32'h8000_1004;
    step("R9");

    // R10: no request
    memReq = 0;
    step("R10");

    // R4: I/O window hit, boundaries and flag bits in the base
    memReq = 0; ioReq = 1; ioAddr = 16'hE07F;
    step("R4");
    ioAddr = 16'hE040;
    step("R4");
    ioAddr = 16'hE080;
    step("R4");
    ioAddr = 16'hE03F;
    step("R4");

    // R5: I/O space off
    cmdIoEn = 0; ioAddr = 16'hE050;
    step("R5");
    cmdIoEn = 1; ioReq = 0;
    step("R10");

    // R6: ROM window hit and edges
    memReq = 1; memAddr = 32'h000C_7FFF;
    step("R6");
    memAddr = 32'h000C_0000;
    step("R6");
    memAddr = 32'h000C_8000;
    step("R6");

    // R7: ROM enable clear
    romBar = 32'h000C_0000; memAddr = 32'h000C_1234;
    step("R7");

    // R8: overlapping memory and ROM windows
    memBarBase = 32'h000C_4000; romBar = 32'h000C_0001; memAddr = 32'h000C_4010;
    step("R8");
    romBar = 32'h000C_0000;
    step("R8");

    // R11: configuration change in the same cycle as the request
    memBarBase = 32'h1234_5000; memAddr = 32'h1234_5678;
    step("R11");
    memBarBase = 32'h1234_6000;
    step("R11");

    // R12: memory and I/O hits in the same cycle
    memBarBase = 32'h1234_5000; memAddr = 32'h1234_5FFF;
    ioReq = 1; ioBarBase = 16'h0301; ioAddr = 16'h0325;
    step("R12");

    // R8: randomized sweep around overlapping windows
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom();
      cmdMemEn = r[0]; cmdIoEn = r[1]; memReq = r[2] | r[3]; ioReq = r[4] | r[5];
      romBar = {$urandom() % 32'h0001_0000, 15'h0} | {31'h0, r[6] | r[7]};
      romBar[14:1] = $urandom();
      memBarBase = {romBar[31:15], 15'h0} + {17'h0, r[10:8], 12'h0} + ($urandom() % 4096);
      ioBarBase = $urandom();
      case (r[12:11])
        2'd0: memAddr = {memBarBase[31:12], 12'h0} + ($urandom() % 4096);
        2'd1: memAddr = {romBar[31:15], 15'h0} + ($urandom() % 32768);
        2'd2: memAddr = {romBar[31:15], 15'h0} + 32'h8000 + ($urandom() % 64);
        default: memAddr = $urandom();
      endcase
      ioAddr = r[13] ? {ioBarBase[15:6], 6'h0} + 16'($urandom() % 64) : 16'($urandom());
      step("R8");
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule